// File: doc/BRIEF.md
# Serial PHY management master (MDC/MDIO)

This block reads and writes the 16-bit registers of an external PHY over a two-wire management bus. It generates a management clock (MDC) from the system clock and drives a bidirectional data line (MDIO) through separate output, output-enable and input pins. A pad cell outside the block joins these three pins to the line. The management clock half-period is set in system clock cycles by a divider input. The divider value is captured when a request is accepted, so it can be changed between transactions but never during one.

A request is offered on a valid/ready handshake. The request pins carry the direction, the 5-bit PHY address, the 5-bit register address and the write data. `req_ready` is high only while the block is idle. A request is taken on a cycle where `req_valid` and `req_ready` are both high. While a transaction runs, `req_ready` stays low and anything offered is left waiting. The response has no back-pressure. On the cycle the transaction ends, `rsp_valid` pulses for one cycle together with the read data and a no-acknowledge flag, and the requester must take them then.

Each transaction takes 65 MDC periods. First come 32 preamble ones. For a write, the 32-bit frame follows. For a read, a 14-bit header follows, the line is released, the PHY's acknowledge is checked, and 16 data bits are shifted in. A final released period closes both kinds.

Top module: `mdio_master`

## Requirements
- R1: While reset is asserted and right after it, `mdc`, `mdio_oe`, `busy` and `rsp_valid` are 0 and `req_ready` is 1.
- R2: Each MDC half-period lasts `div_half`+1 system cycles, and each bit is placed on `mdio_o` while MDC is low and held unchanged through the following high phase. A transaction keeps `busy` high for exactly 130×(`div_half`+1) cycles and produces 65 rising MDC edges.
- R3: MDC periods 0 to 31 of every transaction drive MDIO high with the output enabled (the preamble).
- R4: A write drives, MSB first in periods 32 to 63, the frame {01, 01, phy[4:0], reg[4:0], 10, wdata[15:0]}. It then releases MDIO (`mdio_oe`=0) for period 64.
- R5: A read drives, MSB first in periods 32 to 45, the header {01, 10, phy[4:0], reg[4:0]}. It keeps MDIO released from period 46 through period 64.
- R6: On a read, the acknowledge is the MDIO value sampled at the end of the high phase of period 47. The data bits are sampled at the end of the high phases of periods 48 to 63, MSB first, and are returned on `rsp_rdata` when the acknowledge was 0.
- R7: If the acknowledge was 1, a read returns `rsp_rdata`=16'hFFFF with `rsp_nack`=1. A write returns `rsp_rdata`=0 and `rsp_nack`=0.
- R8: `rsp_valid` is a single-cycle pulse, high on the first cycle with `busy` low after the transaction.
- R9: While `busy` is high, `req_ready` is low and a request held on the inputs starts no transaction, does not alter the frame in flight, and leaves no bus activity after completion.
- R10: A change of `div_half` after a request is accepted has no effect on the timing of that transaction.
- R11: While idle, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_half | input | DIV_W | MDC half-period minus one, in system cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read result (0 for writes) |
| rsp_nack | output | 1 | Read was not acknowledged |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The assertions check on every cycle the properties that need no knowledge of the frame. They cover a quiet, released bus while idle; MDIO data and enable held steady while MDC is high; the single-cycle response pulse arriving only once busy has dropped; the all-ones result on a missing acknowledge; and the divider count staying within the latched half-period. Only the bench scenarios can show the frame contents bit by bit, the period in which the acknowledge and data are sampled, the exact transaction length under several divider values, and that requests offered mid-transaction or divider changes leave the transaction in flight untouched. To do this, the bench models a PHY that answers on chosen MDC periods.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mdio_state_e;

  localparam int ADDR_W     = 5;
  localparam int DATA_W     = 16;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
  localparam int HDR_BITS   = 2 + 2 + 2 * ADDR_W;
  localparam int SHIFT_W    = PRE_BITS + FRAME_BITS;
  localparam int SLOT_TOTAL = PRE_BITS + FRAME_BITS + 1;

  localparam logic [1:0] CODE_START = 2'b01;
  localparam logic [1:0] CODE_RD    = 2'b10;
  localparam logic [1:0] CODE_WR    = 2'b01;
  localparam logic [1:0] CODE_TURN  = 2'b10;

  function automatic logic [SHIFT_W-1:0] build_stream(
    input logic              wr,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg,
    input logic [DATA_W-1:0] wd
  );
    logic [FRAME_BITS-1:0] frm;
    if (wr) frm = {CODE_START, CODE_WR, phy, rg, CODE_TURN, wd};
    else    frm = {CODE_START, CODE_RD, phy, rg, {(FRAME_BITS-HDR_BITS){1'b0}}};
    return {{PRE_BITS{1'b1}}, frm};
  endfunction

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic             run,
  output logic             mdc,
  output logic             slot_end
);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic             half_end;

  assign half_end = run && (cnt_q == div_q);
  assign slot_end = half_end && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else begin
      if (load) div_q <= div_in;
      if (!run) begin
        cnt_q <= '0;
        mdc   <= 1'b0;
      end else if (half_end) begin
        cnt_q <= '0;
        mdc   <= ~mdc;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: the half-period counter never runs past the latched limit
  assert_half_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= div_q));

endmodule

// File: rtl/mdio_tx_shift.sv
module mdio_tx_shift #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         msb
);

  logic [W-1:0] sr_q;

  assign msb = sr_q[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= load_val;
    else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
  end

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          ack_en,
  input  logic          data_en,
  input  logic          din,
  output logic          ack_ok,
  output logic [DW-1:0] data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_ok <= 1'b0;
      data   <= '0;
    end else if (clear) begin
      ack_ok <= 1'b0;
      data   <= '0;
    end else begin
      if (ack_en)  ack_ok <= ~din;
      if (data_en) data   <= {data[DW-2:0], din};
    end
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div_half,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_phy,
  input  logic [ADDR_W-1:0] req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_nack,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);

  localparam int SLOT_W = $clog2(SLOT_TOTAL + 1);
  localparam logic [SLOT_W-1:0] WR_DRIVE_END = SLOT_W'(PRE_BITS + FRAME_BITS);
  localparam logic [SLOT_W-1:0] RD_DRIVE_END = SLOT_W'(PRE_BITS + HDR_BITS);
  localparam logic [SLOT_W-1:0] ACK_SLOT     = SLOT_W'(PRE_BITS + HDR_BITS + 1);
  localparam logic [SLOT_W-1:0] DATA_FIRST   = SLOT_W'(PRE_BITS + HDR_BITS + 2);
  localparam logic [SLOT_W-1:0] DATA_LAST    = SLOT_W'(PRE_BITS + HDR_BITS + 1 + DATA_W);
  localparam logic [SLOT_W-1:0] LAST_SLOT    = SLOT_W'(SLOT_TOTAL - 1);

  mdio_state_e       state_q;
  logic [SLOT_W-1:0] slot_q;
  logic              is_rd_q;
  logic              accept;
  logic              slot_end;
  logic              finish;
  logic              tx_msb;
  logic              ack_en;
  logic              data_en;
  logic              ack_ok;
  logic [DATA_W-1:0] rx_data;
  logic              drive;

  assign req_ready = (state_q == ST_IDLE);
  assign busy      = (state_q == ST_RUN);
  assign accept    = req_valid && req_ready;
  assign finish    = slot_end && (slot_q == LAST_SLOT);

  mdio_clk_div #(.DIV_W(DIV_W)) clk_div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .div_in   (div_half),
    .run      (busy),
    .mdc      (mdc),
    .slot_end (slot_end)
  );

  mdio_tx_shift #(.W(SHIFT_W)) tx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (build_stream(req_write, req_phy, req_reg, req_wdata)),
    .shift    (slot_end),
    .msb      (tx_msb)
  );

  assign ack_en  = slot_end && is_rd_q && (slot_q == ACK_SLOT);
  assign data_en = slot_end && is_rd_q && (slot_q >= DATA_FIRST) && (slot_q <= DATA_LAST);

  mdio_rx_capture #(.DW(DATA_W)) rx_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .ack_en  (ack_en),
    .data_en (data_en),
    .din     (mdio_i),
    .ack_ok  (ack_ok),
    .data    (rx_data)
  );

  always_comb begin
    drive = 1'b0;
    if (busy) drive = is_rd_q ? (slot_q < RD_DRIVE_END) : (slot_q < WR_DRIVE_END);
  end

  assign mdio_oe = drive;
  assign mdio_o  = drive & tx_msb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      is_rd_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_RUN;
          slot_q  <= '0;
          is_rd_q <= ~req_write;
        end
        ST_RUN: if (finish) begin
          state_q <= ST_IDLE;
          slot_q  <= '0;
        end else if (slot_end) begin
          slot_q <= slot_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_nack  <= 1'b0;
    end else begin
      rsp_valid <= finish;
      if (finish) begin
        rsp_nack  <= is_rd_q && !ack_ok;
        rsp_rdata <= !is_rd_q ? '0 : (ack_ok ? rx_data : '1);
      end
    end
  end

  // R11: quiet bus while idle
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R2: line value and enable held through each MDC high phase
  assert_hold_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |=> (!mdc || ($stable(mdio_o) && $stable(mdio_oe))));

  // R8: single-cycle completion pulse
  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: completion reported only after busy has dropped
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

  // R7: a missing acknowledge yields all ones
  assert_nack_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_nack) |-> (rsp_rdata == '1));

endmodule

// File: tb/mdio_master_tb_top.sv
`timescale 1ns/1ps
module mdio_master_tb_top;

  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [DIV_W-1:0] div_half = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        mdio_i = 1'b1;
  logic        req_ready, busy, rsp_valid, rsp_nack, mdc, mdio_o, mdio_oe;
  logic [15:0] rsp_rdata;

  mdio_master #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .div_half(div_half),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_nack(rsp_nack),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0;
  int n_bad = 0;

  // bus monitor and PHY model
  int   rise_cnt = 0, busy_cnt = 0, ready_err = 0, idle_err = 0;
  logic prev_mdc = 1'b0;
  logic rec_oe [0:79];
  logic rec_bit[0:79];
  logic phy_ack_low = 1'b1;
  logic [15:0] phy_data = '0;

  always @(negedge clk) begin
    if (mdc === 1'b1 && prev_mdc === 1'b0) begin
      if (rise_cnt < 80) begin
        rec_oe[rise_cnt]  = mdio_oe;
        rec_bit[rise_cnt] = mdio_o;
      end
      if (rise_cnt == 47) mdio_i = phy_ack_low ? 1'b0 : 1'b1;
      else if (rise_cnt >= 48 && rise_cnt <= 63) mdio_i = phy_data[63-rise_cnt];
      else mdio_i = 1'b1;
      rise_cnt++;
    end
    prev_mdc = mdc;
    if (busy === 1'b1) begin
      busy_cnt++;
      if (req_ready !== 1'b0) ready_err++;
    end else if (busy === 1'b0) begin
      if (mdc !== 1'b0 || mdio_oe !== 1'b0) idle_err++;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input int d, input bit ack_low,
                         input logic [15:0] pd, input bit change_div, input bit poke);
    logic [31:0] frm;
    int pre_bad, frm_bad, waitn;
    logic exp_oe, exp_b;
    logic [15:0] exp_rd;
    frm = wr ? {2'b01, 2'b01, phy, rg, 2'b10, wd} : {2'b01, 2'b10, phy, rg, 18'b0};
    @(negedge clk);
    div_half = DIV_W'(d);
    phy_ack_low = ack_low; phy_data = pd;
    req_write = wr; req_phy = phy; req_reg = rg; req_wdata = wd; req_valid = 1'b1;
    rise_cnt = 0; busy_cnt = 0; ready_err = 0; idle_err = 0;
    @(negedge clk);
    req_valid = 1'b0;
    if (change_div) div_half = '0;
    if (poke) begin
      repeat (20) @(negedge clk);
      req_valid = 1'b1; req_write = ~wr; req_phy = ~phy; req_reg = ~rg; req_wdata = ~wd;
      repeat (30) @(negedge clk);
      req_valid = 1'b0;
    end
    waitn = 0;
    while (rsp_valid !== 1'b1 && waitn < 40000) begin
      @(negedge clk);
      waitn++;
    end
    chk(rsp_valid === 1'b1, "R8", "completion pulse", rsp_valid, 1);
    chk(busy_cnt == 130 * (d + 1), change_div ? "R10" : "R2", "busy cycles", busy_cnt, 130 * (d + 1));
    chk(rise_cnt == 65, "R2", "MDC rising edges", rise_cnt, 65);
    pre_bad = 0; frm_bad = 0;
    for (int k = 0; k < 65; k++) begin
      exp_oe = wr ? (k < 64) : (k < 46);
      if (k < 32) exp_b = 1'b1;
      else if (k < 64) exp_b = frm[63-k];
      else exp_b = 1'b0;
      if (rec_oe[k] !== exp_oe || (exp_oe && rec_bit[k] !== exp_b)) begin
        if (k < 32) pre_bad++; else frm_bad++;
      end
    end
    chk(pre_bad == 0, "R3", "preamble periods wrong", pre_bad, 0);
    chk(frm_bad == 0, wr ? "R4" : "R5", "frame periods wrong", frm_bad, 0);
    exp_rd = wr ? 16'h0000 : (ack_low ? pd : 16'hFFFF);
    chk(rsp_rdata === exp_rd, wr ? "R7" : (ack_low ? "R6" : "R7"), "read data", rsp_rdata, exp_rd);
    chk(rsp_nack === (!wr && !ack_low), "R7", "nack flag", rsp_nack, (!wr && !ack_low));
    if (poke) chk(ready_err == 0, "R9", "ready high while busy", ready_err, 0);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R8", "pulse longer than one cycle", rsp_valid, 0);
    repeat (10) @(negedge clk);
    if (poke) chk(busy === 1'b0 && rise_cnt == 65, "R9", "extra activity after done", rise_cnt, 65);
    chk(idle_err == 0, "R11", "bus active while idle", idle_err, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0, "R1", "bus in reset", {mdc, mdio_oe}, 0);
    chk(busy === 1'b0 && rsp_valid === 1'b0 && req_ready === 1'b1, "R1", "handshake in reset",
        {busy, rsp_valid, req_ready}, 3'b001);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0 && busy === 1'b0 && req_ready === 1'b1, "R1",
        "state after reset", {mdc, mdio_oe, busy, req_ready}, 4'b0001);

    // R2 R4: writes across divider settings
    for (int d = 0; d < 4; d++) begin
      run_txn(1'b1, 5'(d * 7 + 1), 5'(30 - d), 16'hFFFF >> d, d, 1'b1, 16'h0, 1'b0, 1'b0);
      run_txn(1'b1, 5'(31 - d), 5'(d), 16'h0001 << (d * 4), d, 1'b1, 16'h0, 1'b0, 1'b0);
    end
    // R5 R6: reads sweeping every PHY address
    for (int p = 0; p < 32; p++)
      run_txn(1'b0, 5'(p), 5'(31 - p), {5'(p), 11'h5A3}, 0, 1'b1, {5'(p), 11'h5A3}, 1'b0, 1'b0);
    // R4: writes sweeping every register address
    for (int r = 0; r < 32; r++)
      run_txn(1'b1, 5'h13, 5'(r), 16'(r * 16'h0811), 0, 1'b1, 16'h0, 1'b0, 1'b0);
    // R6 R7: data extremes and missing acknowledge
    run_txn(1'b0, 5'h0A, 5'h02, 16'h0, 2, 1'b1, 16'hFFFF, 1'b0, 1'b0);
    run_txn(1'b0, 5'h15, 5'h1F, 16'h0, 1, 1'b1, 16'h0000, 1'b0, 1'b0);
    run_txn(1'b0, 5'h01, 5'h01, 16'h0, 1, 1'b0, 16'h1234, 1'b0, 1'b0);
    run_txn(1'b0, 5'h1F, 5'h00, 16'h0, 3, 1'b0, 16'h0000, 1'b0, 1'b0);
    // R10: divider changed mid-transaction
    run_txn(1'b1, 5'h04, 5'h09, 16'hC3A5, 2, 1'b1, 16'h0, 1'b1, 1'b0);
    run_txn(1'b0, 5'h0C, 5'h11, 16'h0, 3, 1'b1, 16'h6E01, 1'b1, 1'b0);
    // R9: request offered while busy
    run_txn(1'b1, 5'h06, 5'h0E, 16'h9F0C, 1, 1'b1, 16'h0, 1'b0, 1'b1);
    run_txn(1'b0, 5'h1B, 5'h07, 16'h0, 0, 1'b1, 16'hB00F, 1'b0, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule